// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic unit of a small microcontroller core. Each cycle it takes two operands, an operation code and the carry held in its own status register. It produces a combinational result and a set of new flag values. When `opValid` is high, the status register captures the flags at the next rising clock edge. Each operation writes only the flags that belong to it and leaves the others as they were. This lets a following instruction depend on a carry or half-carry set several operations earlier.

The status register holds six flags. The bit positions are fixed: bit 0 is carry C, bit 1 is zero Z, bit 2 is negative N, bit 3 is overflow V, bit 4 is sign S and bit 5 is half-carry H.

The operation codes on `opSel` are:

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | add with carry |
| 2 | subtract |
| 3 | subtract with carry |
| 4 | AND |
| 5 | OR |
| 6 | XOR |
| 7 | one's complement |
| 8 | two's complement |
| 9 | increment |
| 10 | decrement |
| 11 | shift left |
| 12 | logical shift right |
| 13 | rotate left through carry |
| 14 | rotate right through carry |
| 15 | arithmetic shift right |
| 16 | nibble swap |

Codes 17 to 31 are not assigned.

Top module: `alu8_core`

## Requirements
- R1: Add (code 0) gives opA+opB. It updates C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N (result bit 7) and Z (result is zero).
- R2: Add with carry (code 1) gives opA+opB+C. It updates the same five flags as add.
- R3: Subtract (code 2) gives opA-opB and subtract with carry (code 3) gives opA-opB-C. Both update C (borrow out of bit 7), H (borrow into bit 4), V, N and Z.
- R4: AND, OR and XOR (codes 4, 5, 6) update only Z and N, and clear V. C and H keep their previous values.
- R5: One's complement (code 7) gives 0xFF-opA. It sets C to 1, clears V and updates Z and N. H is unchanged.
- R6: Two's complement (code 8) gives 0x00-opA. It updates C, H, V, N and Z as a subtraction from zero would.
- R7: Increment and decrement (codes 9, 10) update Z, N and V. V is 1 exactly when the signed result wraps. C and H are never changed.
- R8: Shift left (code 11) inserts 0 at bit 0. Logical shift right (code 12) inserts 0 at bit 7. In both, C takes the bit shifted out, and Z, N and V update. H is unchanged.
- R9: Rotate left (code 13) moves C into bit 0 and bit 7 into C. Rotate right (code 14) moves C into bit 7 and bit 0 into C.
- R10: Arithmetic shift right (code 15) keeps bit 7, shifts bits 7..1 down and moves bit 0 into C. For every shift and rotate, V equals N XOR the new C.
- R11: Nibble swap (code 16) exchanges bits 7..4 with bits 3..0 and changes no flag.
- R12: Unassigned codes (17 to 31) pass opA to the result and change no flag.
- R13: When `opValid` is low the status register holds its value. After reset all six flags are 0.
- R14: Whenever an operation writes N or V, S is written as N XOR V. Otherwise S is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset of the status register |
| opValid | input | 1 | Allows the status register to capture the new flags |
| opSel | input | 5 | Operation code |
| opA | input | 8 | First operand, and the only operand of single-operand operations |
| opB | input | 8 | Second operand |
| result | output | 8 | Combinational result of the selected operation |
| status | output | 6 | Registered flags {H,S,V,N,Z,C} |

## Verification
Three properties are checked by assertions on every clocked cycle:
- S stays equal to N XOR V.
- Logic operations, increment and decrement preserve carry, and logic operations also preserve half-carry.
- One's complement forces carry, and nibble swap, unassigned codes and idle cycles leave the register unchanged.

The arithmetic values themselves can only be shown by the bench's directed scenarios. These include the result bytes, carry and borrow out of bits 3 and 7, the signed-overflow corners at 0x7F and 0x80, and the bits pulled in by shifts and rotates from a carry preset by an earlier operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;
  localparam int FLAG_COUNT = 6;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_COM  = 5'd7,
    OP_NEG  = 5'd8,
    OP_INC  = 5'd9,
    OP_DEC  = 5'd10,
    OP_LSL  = 5'd11,
    OP_LSR  = 5'd12,
    OP_ROL  = 5'd13,
    OP_ROR  = 5'd14,
    OP_ASR  = 5'd15,
    OP_SWAP = 5'd16
  } aluOp_e;

  typedef enum logic [2:0] {
    UNIT_ARITH,
    UNIT_LOGIC,
    UNIT_COM,
    UNIT_STEP,
    UNIT_SHIFT,
    UNIT_SWAP,
    UNIT_PASS
  } aluUnit_e;

  typedef enum logic [1:0] {
    LOG_AND,
    LOG_OR,
    LOG_XOR
  } logicFn_e;

  typedef enum logic [2:0] {
    SH_LSL,
    SH_LSR,
    SH_ROL,
    SH_ROR,
    SH_ASR
  } shiftFn_e;

  // Strobes from the control to the datapath and the status register.
  typedef struct packed {
    aluUnit_e unit;
    logic     subtract;
    logic     useCarry;
    logic     negate;
    logicFn_e logicFn;
    logic     stepDown;
    shiftFn_e shiftFn;
    logic     updC;
    logic     updZ;
    logic     updNV;
    logic     updH;
  } aluCtrl_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [4:0] opSel,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '{unit: UNIT_PASS, subtract: 1'b0, useCarry: 1'b0, negate: 1'b0,
             logicFn: LOG_AND, stepDown: 1'b0, shiftFn: SH_LSL,
             updC: 1'b0, updZ: 1'b0, updNV: 1'b0, updH: 1'b0};
    case (opSel)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        ctrl.unit     = UNIT_ARITH;
        ctrl.subtract = (opSel == OP_SUB) || (opSel == OP_SBC) || (opSel == OP_NEG);
        ctrl.useCarry = (opSel == OP_ADC) || (opSel == OP_SBC);
        ctrl.negate   = (opSel == OP_NEG);
        ctrl.updC  = 1'b1;
        ctrl.updZ  = 1'b1;
        ctrl.updNV = 1'b1;
        ctrl.updH  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctrl.unit    = UNIT_LOGIC;
        ctrl.logicFn = (opSel == OP_AND) ? LOG_AND :
                       (opSel == OP_OR)  ? LOG_OR  : LOG_XOR;
        ctrl.updZ  = 1'b1;
        ctrl.updNV = 1'b1;
      end
      OP_COM: begin
        ctrl.unit  = UNIT_COM;
        ctrl.updC  = 1'b1;
        ctrl.updZ  = 1'b1;
        ctrl.updNV = 1'b1;
      end
      OP_INC, OP_DEC: begin
        ctrl.unit     = UNIT_STEP;
        ctrl.stepDown = (opSel == OP_DEC);
        ctrl.updZ  = 1'b1;
        ctrl.updNV = 1'b1;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        ctrl.unit = UNIT_SHIFT;
        case (opSel)
          OP_LSL:  ctrl.shiftFn = SH_LSL;
          OP_LSR:  ctrl.shiftFn = SH_LSR;
          OP_ROL:  ctrl.shiftFn = SH_ROL;
          OP_ROR:  ctrl.shiftFn = SH_ROR;
          default: ctrl.shiftFn = SH_ASR;
        endcase
        ctrl.updC  = 1'b1;
        ctrl.updZ  = 1'b1;
        ctrl.updNV = 1'b1;
      end
      OP_SWAP: ctrl.unit = UNIT_SWAP;
      default: ctrl.unit = UNIT_PASS;
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              newC,
  output logic              newZ,
  output logic              newN,
  output logic              newV,
  output logic              newH
);

  localparam int MSB  = DATA_W - 1;
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] arX, arY, arRes, stepRes, shRes;
  logic [DATA_W:0]   arWide;
  logic              arCin, arV, arH, stepV, shC;

  // Adder / subtractor shared by add, subtract and two's complement
  always_comb begin
    arX   = ctrl.negate ? '0 : opA;
    arY   = ctrl.negate ? opA : opB;
    arCin = ctrl.useCarry & carryIn;
    if (ctrl.subtract)
      arWide = {1'b0, arX} - {1'b0, arY} - {{DATA_W{1'b0}}, arCin};
    else
      arWide = {1'b0, arX} + {1'b0, arY} + {{DATA_W{1'b0}}, arCin};
    arRes = arWide[MSB:0];
    arH   = arX[HALF] ^ arY[HALF] ^ arRes[HALF];
    if (ctrl.subtract)
      arV = (arX[MSB] != arY[MSB]) && (arRes[MSB] != arX[MSB]);
    else
      arV = (arX[MSB] == arY[MSB]) && (arRes[MSB] != arX[MSB]);
  end

  // Increment / decrement
  always_comb begin
    stepRes = ctrl.stepDown ? opA - 1'b1 : opA + 1'b1;
    stepV   = (stepRes[MSB] != opA[MSB]) && (opA[MSB] == ctrl.stepDown);
  end

  // Shifts and rotates
  always_comb begin
    case (ctrl.shiftFn)
      SH_LSL:  begin shRes = {opA[MSB-1:0], 1'b0};     shC = opA[MSB]; end
      SH_ROL:  begin shRes = {opA[MSB-1:0], carryIn};  shC = opA[MSB]; end
      SH_LSR:  begin shRes = {1'b0, opA[MSB:1]};       shC = opA[0];   end
      SH_ROR:  begin shRes = {carryIn, opA[MSB:1]};    shC = opA[0];   end
      default: begin shRes = {opA[MSB], opA[MSB:1]};   shC = opA[0];   end
    endcase
  end

  always_comb begin
    newC = carryIn;
    newV = 1'b0;
    newH = arH;
    case (ctrl.unit)
      UNIT_ARITH: begin result = arRes; newC = arWide[DATA_W]; newV = arV; end
      UNIT_LOGIC: begin
        case (ctrl.logicFn)
          LOG_AND: result = opA & opB;
          LOG_OR:  result = opA | opB;
          default: result = opA ^ opB;
        endcase
      end
      UNIT_COM:   begin result = ~opA; newC = 1'b1; end
      UNIT_STEP:  begin result = stepRes; newV = stepV; end
      UNIT_SHIFT: begin result = shRes; newC = shC; newV = shRes[MSB] ^ shC; end
      UNIT_SWAP:  result = {opA[HALF-1:0], opA[MSB:HALF]};
      default:    result = opA;
    endcase
    newN = result[MSB];
    newZ = (result == '0);
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opValid,
  input  logic [4:0]            opSel,
  input  logic [DATA_W-1:0]     opA,
  input  logic [DATA_W-1:0]     opB,
  output logic [DATA_W-1:0]     result,
  output logic [FLAG_COUNT-1:0] status
);

  aluCtrl_t              ctrl;
  logic                  newC, newZ, newN, newV, newH;
  logic [FLAG_COUNT-1:0] statusQ, statusD;

  alu8_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu8_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .carryIn (statusQ[FLAG_C]),
    .result  (result),
    .newC    (newC),
    .newZ    (newZ),
    .newN    (newN),
    .newV    (newV),
    .newH    (newH)
  );

  always_comb begin
    statusD = statusQ;
    if (ctrl.updC)  statusD[FLAG_C] = newC;
    if (ctrl.updZ)  statusD[FLAG_Z] = newZ;
    if (ctrl.updH)  statusD[FLAG_H] = newH;
    if (ctrl.updNV) begin
      statusD[FLAG_N] = newN;
      statusD[FLAG_V] = newV;
      statusD[FLAG_S] = newN ^ newV;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        statusQ <= '0;
    else if (opValid) statusQ <= statusD;
  end

  assign status = statusQ;

  // R14
  sign_rel_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[FLAG_S] == (statusQ[FLAG_N] ^ statusQ[FLAG_V]));

  // R4
  logic_keeps_ch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR))
    |=> ($stable(statusQ[FLAG_C]) && $stable(statusQ[FLAG_H]) && !statusQ[FLAG_V]));

  // R5
  com_sets_c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_COM) |=> (statusQ[FLAG_C] && !statusQ[FLAG_V]));

  // R7
  step_keeps_c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == OP_INC || opSel == OP_DEC)) |=> $stable(statusQ[FLAG_C]));

  // R11
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_SWAP) |=> $stable(statusQ));

  // R12
  unassigned_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel > OP_SWAP) |=> $stable(statusQ));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(statusQ));

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [4:0] opSel;
  logic [7:0] opA, opB;
  logic [7:0] result;
  logic [5:0] status;

  int testsRun = 0;
  int testsFail = 0;

  always #5 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .opA(opA), .opB(opB), .result(result), .status(status)
  );

  // Opcodes as listed in the brief
  localparam logic [4:0] ADD = 0, ADC = 1, SUB = 2, SBC = 3, AND_ = 4, OR_ = 5,
    XOR_ = 6, COM = 7, NEG = 8, INC = 9, DEC = 10, LSL = 11, LSR = 12,
    ROL = 13, ROR = 14, ASR = 15, SWAP = 16;

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkFlags(string req, logic [5:0] exp);
    testsRun++;
    if (status !== exp) begin
      testsFail++;
      $display("FAIL %s flags actual=%b expected=%b", req, status, exp);
    end
  endtask

  // Called at a falling edge: drive, check the result, then check the flags
  // one rising edge later.
  task automatic doOp(string req, logic [4:0] op, logic [7:0] a, logic [7:0] b,
                      logic [7:0] expRes, logic [5:0] expFlags);
    opValid = 1'b1; opSel = op; opA = a; opB = b;
    #1;
    check8(req, "result", result, expRes);
    @(negedge clk);
    checkFlags(req, expFlags);
    opValid = 1'b0;
  endtask

  task automatic testReset();
    checkFlags("R13", 6'b000000);
  endtask

  task automatic testAdd();
    doOp("R1", ADD, 8'h0F, 8'h01, 8'h10, 6'b100000);
    doOp("R1", ADD, 8'h80, 8'h80, 8'h00, 6'b011011);
    doOp("R2", ADC, 8'h01, 8'h01, 8'h03, 6'b000000);
  endtask

  task automatic testSub();
    doOp("R3", SUB, 8'h00, 8'h01, 8'hFF, 6'b110101);
    doOp("R3", SBC, 8'h50, 8'h10, 8'h3F, 6'b100000);
    doOp("R3", SUB, 8'h80, 8'h01, 8'h7F, 6'b111000);
  endtask

  task automatic testLogic();
    doOp("R4", SUB, 8'h00, 8'h01, 8'hFF, 6'b110101);
    doOp("R4", AND_, 8'hF0, 8'h0F, 8'h00, 6'b100011);
    doOp("R4", OR_, 8'h80, 8'h01, 8'h81, 6'b110101);
    doOp("R4", XOR_, 8'hAA, 8'hAA, 8'h00, 6'b100011);
  endtask

  task automatic testCom();
    doOp("R5", ADD, 8'h00, 8'h00, 8'h00, 6'b000010);
    doOp("R5", COM, 8'h00, 8'h00, 8'hFF, 6'b010101);
  endtask

  task automatic testNeg();
    doOp("R6", NEG, 8'h01, 8'h00, 8'hFF, 6'b110101);
    doOp("R6", NEG, 8'h80, 8'h00, 8'h80, 6'b001101);
    doOp("R6", NEG, 8'h00, 8'h00, 8'h00, 6'b000010);
  endtask

  task automatic testStep();
    doOp("R7", SUB, 8'h00, 8'h01, 8'hFF, 6'b110101);
    doOp("R7", INC, 8'h7F, 8'h00, 8'h80, 6'b101101);
    doOp("R7", DEC, 8'h01, 8'h00, 8'h00, 6'b100011);
    doOp("R7", DEC, 8'h80, 8'h00, 8'h7F, 6'b111001);
  endtask

  task automatic testShifts();
    doOp("R8", LSL, 8'h81, 8'h00, 8'h02, 6'b111001);
    doOp("R8", LSR, 8'h01, 8'h00, 8'h00, 6'b111011);
    doOp("R9", ROL, 8'h80, 8'h00, 8'h01, 6'b111001);
    doOp("R9", ROR, 8'h01, 8'h00, 8'h80, 6'b110101);
    doOp("R9", ADD, 8'h00, 8'h00, 8'h00, 6'b000010);
    doOp("R9", ROR, 8'h02, 8'h00, 8'h01, 6'b000000);
    doOp("R10", ASR, 8'h81, 8'h00, 8'hC0, 6'b010101);
  endtask

  task automatic testSwapAndIdle();
    doOp("R11", SWAP, 8'h3C, 8'h00, 8'hC3, 6'b010101);
    doOp("R12", 5'd20, 8'h5A, 8'hFF, 8'h5A, 6'b010101);
    // Idle cycle: an add that would change every flag must not land
    opValid = 1'b0; opSel = ADD; opA = 8'h80; opB = 8'h80;
    @(negedge clk);
    checkFlags("R13", 6'b010101);
    doOp("R14", ADD, 8'h7F, 8'h01, 8'h80, 6'b101100);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    testsRun++;
    testsFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; opValid = 1'b0; opSel = '0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAdd();
    testSub();
    testLogic();
    testCom();
    testNeg();
    testStep();
    testShifts();
    testSwapAndIdle();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule